// File: doc/BRIEF.md
# Serial Receive Channel with Flagged Character Queue

This block turns an asynchronous serial line into a stream of characters. A single-cycle sample enable, pulsing at sixteen times the bit rate, drives the timing. Each character has a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Each character leaves the block together with three status flags: parity error, framing error and break. The flags stay attached to their own character.

After reset the channel holds one character at a time. When the `fifo_mode` control input is raised, the channel switches to a sixteen-entry first-in first-out queue. Either change of mode empties the storage and clears the sticky overrun flag.

In queued mode an optional automatic flow control drives `rts` low as the queue nears full, so that the remote sender pauses before any character is lost. A DMA-oriented ready pin reports that characters are waiting.

The read side is a valid/ready stream. `out_valid` rises when a character is stored, and a transfer happens on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the word and its flags do not change. Holding `out_ready` low only fills the storage. Once the storage is full, further characters are dropped and `overrun` is set.

Top module: `serial_rx_channel`

## Requirements
- R1: After reset, `out_valid`, `dma_rx_rdy` and `overrun` are 0 and `rts` is 1.
- R2: A start bit is accepted only if the line is still low on the 8th sample tick after the falling edge. Data bits are then taken every 16 ticks, least significant bit first. A low pulse shorter than 8 ticks yields no character.
- R3: When `parity_on` is 1, a parity bit follows the data bits. `parity_odd` = 0 selects even parity and 1 selects odd parity. A mismatch sets `out_perr` for that character. When `parity_on` is 0, `out_perr` is 0.
- R4: A stop bit sampled low sets `out_ferr` for that character.
- R5: A frame whose data bits, parity bit (if enabled) and stop bit are all low sets `out_brk`, together with `out_ferr`.
- R6: In single mode (`fifo_mode` = 0) one character is held. A character that completes while one is already held is discarded and sets `overrun`. `overrun` stays set until the mode changes or reset.
- R7: In queued mode (`fifo_mode` = 1), up to 16 characters are stored and delivered in arrival order, each with its own flags. A 17th character is discarded and sets `overrun`.
- R8: Any change of `fifo_mode` empties the storage and clears `overrun`.
- R9: With `auto_flow` = 1 in queued mode, `rts` goes to 0 one cycle after occupancy reaches 14. It returns to 1 one cycle after occupancy falls below 8, and keeps its value in between. In all other cases `rts` is 1.
- R10: `dma_rx_rdy` equals `out_valid`. A character is removed only on an edge with `out_valid` and `out_ready` both high, and the word stays stable while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle enable at 16x bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| fifo_mode | input | 1 | 0 = single character, 1 = 16-entry queue |
| auto_flow | input | 1 | Enables automatic RTS control in queued mode |
| parity_on | input | 1 | Frame carries a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| out_valid | output | 1 | A character is available |
| out_ready | input | 1 | Consumer accepts the character |
| out_data | output | 8 | Character data |
| out_perr | output | 1 | Parity error flag of the character |
| out_ferr | output | 1 | Framing error flag of the character |
| out_brk | output | 1 | Break flag of the character |
| dma_rx_rdy | output | 1 | DMA request: characters waiting |
| overrun | output | 1 | Sticky: a character was discarded |
| rts | output | 1 | Request to send, 0 asks the sender to pause |

## Verification
A character appears at the stream outputs about three clock cycles after the mid-stop sample: two synchronizer stages, the sampler register and the queue write. The bench therefore holds every stop bit a full bit time and samples only after it has ended. A pop takes effect at the edge where `out_ready` is high, and `rts` follows the new occupancy one edge later, so the bench waits two edges after a pop before it checks `rts`. All sampling happens on falling clock edges, away from the edges that update the design.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_word_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_t;
endpackage

// File: rtl/rxc_sampler.sv
module rxc_sampler
  import rxc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OVERSAMPLE  = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     line_in,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     ch_valid,
  output rx_word_t ch_word
);
  localparam int CW  = $clog2(OVERSAMPLE);
  localparam int IW  = $clog2(DATA_W);
  localparam int MID = OVERSAMPLE / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= line_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  logic              rx_s;
  assign rx_s = sync_q[SYNC_STAGES-1];

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              prev_hi;
  logic              at_mid;
  logic              at_end;

  assign at_mid = (cnt == CW'(MID - 1));
  assign at_end = (cnt == CW'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      prev_hi  <= 1'b1;
      ch_valid <= 1'b0;
      ch_word  <= '0;
    end else begin
      ch_valid <= 1'b0;
      if (tick) begin
        prev_hi <= rx_s;
        cnt     <= cnt + 1'b1;
        unique case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (prev_hi && !rx_s) state <= ST_START;
          end
          ST_START: if (at_mid) begin
            cnt   <= '0;
            idx   <= '0;
            state <= rx_s ? ST_IDLE : ST_DATA;
          end
          ST_DATA: if (at_end) begin
            shreg <= {rx_s, shreg[DATA_W-1:1]};
            idx   <= idx + 1'b1;
            if (idx == IW'(DATA_W - 1)) state <= par_en ? ST_PAR : ST_STOP;
          end
          ST_PAR: if (at_end) begin
            par_bit <= rx_s;
            state   <= ST_STOP;
          end
          ST_STOP: if (at_end) begin
            ch_valid     <= 1'b1;
            ch_word.data <= shreg;
            ch_word.perr <= par_en & (^shreg ^ par_bit ^ par_odd);
            ch_word.ferr <= ~rx_s;
            ch_word.brk  <= ~rx_s & (shreg == '0) & ~(par_en & par_bit);
            state        <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  a_r5_break_implies_framing: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid && ch_word.brk |-> ch_word.ferr);
  a_r3_no_perr_without_parity: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid && !par_en && $stable(par_en) |-> !ch_word.perr);
endmodule

// File: rtl/rxc_queue.sv
module rxc_queue
  import rxc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       queue_en,
  input  logic                       push,
  input  rx_word_t                   push_word,
  input  logic                       pop_ready,
  output logic                       head_valid,
  output rx_word_t                   head_word,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovr
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rx_word_t        mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic            mode_q;
  logic            flush;
  logic [CW-1:0]   cap;
  logic            do_push, do_pop;

  assign flush      = (queue_en != mode_q);
  assign cap        = queue_en ? CW'(DEPTH) : CW'(1);
  assign head_valid = (count != '0);
  assign head_word  = mem[rd_ptr];
  assign do_pop     = head_valid && pop_ready && !flush;
  assign do_push    = push && !flush && (count < cap);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= queue_en;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
        ovr    <= 1'b0;
      end else begin
        if (do_push) wr_ptr <= bump(wr_ptr);
        if (do_pop)  rd_ptr <= bump(rd_ptr);
        count <= count + CW'(do_push) - CW'(do_pop);
        if (push && !do_push) ovr <= 1'b1;
      end
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r6_single_holds_one: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_en && !mode_q |-> count <= CW'(1));
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && (queue_en == mode_q) |=> ovr);
  a_r10_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid && !pop_ready |=> !head_valid || $stable(head_word));
endmodule

// File: rtl/rxc_flow.sv
module rxc_flow #(
  parameter int CW       = 5,
  parameter int PAUSE_AT = 14,
  parameter int RESUME_BELOW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] level,
  output logic          rts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         rts <= 1'b1;
    else if (!enable)                   rts <= 1'b1;
    else if (level >= CW'(PAUSE_AT))    rts <= 1'b0;
    else if (level <  CW'(RESUME_BELOW)) rts <= 1'b1;
  end

  a_r9_free_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> rts);
  a_r9_pause_high_level: assert property (@(posedge clk) disable iff (!rst_n)
    enable && level >= CW'(PAUSE_AT) |=> !rts);
  a_r9_hysteresis_hold: assert property (@(posedge clk) disable iff (!rst_n)
    enable && level >= CW'(RESUME_BELOW) && level < CW'(PAUSE_AT) |=> rts == $past(rts));
endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
  import rxc_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int OVERSAMPLE   = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int PAUSE_AT     = 14,
  parameter int RESUME_BELOW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rx_line,
  input  logic              fifo_mode,
  input  logic              auto_flow,
  input  logic              parity_on,
  input  logic              parity_odd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              out_brk,
  output logic              dma_rx_rdy,
  output logic              overrun,
  output logic              rts
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          ch_valid;
  rx_word_t      ch_word;
  rx_word_t      head;
  logic [CW-1:0] level;

  rxc_sampler #(.SYNC_STAGES(SYNC_STAGES), .OVERSAMPLE(OVERSAMPLE)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .line_in(rx_line),
    .par_en(parity_on), .par_odd(parity_odd),
    .ch_valid(ch_valid), .ch_word(ch_word)
  );

  rxc_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .queue_en(fifo_mode),
    .push(ch_valid), .push_word(ch_word), .pop_ready(out_ready),
    .head_valid(out_valid), .head_word(head), .count(level), .ovr(overrun)
  );

  rxc_flow #(.CW(CW), .PAUSE_AT(PAUSE_AT), .RESUME_BELOW(RESUME_BELOW)) u_flow (
    .clk(clk), .rst_n(rst_n), .enable(auto_flow & fifo_mode),
    .level(level), .rts(rts)
  );

  assign out_data   = head.data;
  assign out_perr   = head.perr;
  assign out_ferr   = head.ferr;
  assign out_brk    = head.brk;
  assign dma_rx_rdy = out_valid;
endmodule

// File: tb/serial_rx_channel_bench.sv
module serial_rx_channel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic rx_line = 1'b1;
  logic fifo_mode = 1'b0, auto_flow = 1'b0, parity_on = 1'b0, parity_odd = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid, out_perr, out_ferr, out_brk, dma_rx_rdy, overrun, rts;
  logic [7:0] out_data;
  int checks = 0, errors = 0;
  bit done = 0;
  int tdiv = 0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    sample_tick <= (tdiv == 3);
  end

  serial_rx_channel u_serial_rx_channel (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
    .fifo_mode(fifo_mode), .auto_flow(auto_flow), .parity_on(parity_on),
    .parity_odd(parity_odd), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_perr(out_perr), .out_ferr(out_ferr),
    .out_brk(out_brk), .dma_rx_rdy(dma_rx_rdy), .overrun(overrun), .rts(rts)
  );

  localparam int BITCLK = 64;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    rx_line = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit flip_par, input logic stop_v);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (parity_on) hold_bit((^d) ^ parity_odd ^ flip_par);
    hold_bit(stop_v);
    hold_bit(1'b1);
  endtask

  task automatic pop_expect(input string req, input logic [7:0] d,
                            input logic p, input logic f, input logic b);
    check({req, " valid"}, out_valid, 1);
    check({req, " data"}, out_data, d);
    check({req, " flags"}, {out_perr, out_ferr, out_brk}, {p, f, b});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", out_valid, 0);
    check("R1 dma", dma_rx_rdy, 0);
    check("R1 overrun", overrun, 0);
    check("R1 rts", rts, 1);

    // R2, R10 single mode basic
    send(8'hA5, 0, 1);
    check("R10 dma_rx_rdy", dma_rx_rdy, 1);
    pop_expect("R2 single", 8'hA5, 0, 0, 0);
    check("R10 empty after pop", out_valid, 0);

    // R6 overrun in single mode
    send(8'h11, 0, 1);
    send(8'h22, 0, 1);
    check("R6 overrun", overrun, 1);
    pop_expect("R6 first kept", 8'h11, 0, 0, 0);
    check("R6 second dropped", out_valid, 0);
    check("R6 sticky", overrun, 1);

    // R2 glitch shorter than 8 ticks
    rx_line = 1'b0;
    repeat (20) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    check("R2 glitch ignored", out_valid, 0);

    // R8 mode switch clears overrun
    fifo_mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 overrun cleared", overrun, 0);

    // R2/R3 sweep in queued mode, batches of 8
    for (int bt = 0; bt < 6; bt++) begin
      parity_on  = (bt % 3) != 0;
      parity_odd = (bt % 3) == 2;
      for (int k = 0; k < 8; k++) send(8'((bt * 8 + k) * 37 + 5), 0, 1);
      for (int k = 0; k < 8; k++) pop_expect("R2 sweep", 8'((bt * 8 + k) * 37 + 5), 0, 0, 0);
    end

    // R3 parity errors, R4 framing, R5 break; R7 flags stay attached
    parity_on = 1'b1; parity_odd = 1'b0;
    send(8'h3C, 1, 1);
    parity_odd = 1'b1;
    send(8'h3D, 1, 1);
    send(8'h3E, 0, 1);
    parity_on = 1'b0;
    send(8'h81, 0, 0);
    send(8'h00, 0, 0);
    send(8'h00, 0, 1);
    pop_expect("R3 even bad", 8'h3C, 1, 0, 0);
    pop_expect("R3 odd bad", 8'h3D, 1, 0, 0);
    pop_expect("R7 good between", 8'h3E, 0, 0, 0);
    pop_expect("R4 framing", 8'h81, 0, 1, 0);
    pop_expect("R5 break", 8'h00, 0, 1, 1);
    pop_expect("R5 zero not break", 8'h00, 0, 0, 0);

    // R9 / R7 fill
    for (int k = 0; k < 14; k++) send(8'h40 + 8'(k), 0, 1);
    check("R9 flow off rts", rts, 1);
    auto_flow = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 pause at 14", rts, 0);
    send(8'h4E, 0, 1);
    send(8'h4F, 0, 1);
    check("R7 16 fit", overrun, 0);
    send(8'h99, 0, 1);
    check("R7 17th overrun", overrun, 1);
    for (int k = 0; k < 8; k++) pop_expect("R7 order", 8'h40 + 8'(k), 0, 0, 0);
    check("R9 hold at 8", rts, 0);
    pop_expect("R7 order", 8'h48, 0, 0, 0);
    @(negedge clk);
    check("R9 resume below 8", rts, 1);
    for (int k = 9; k < 16; k++) pop_expect("R7 order", 8'h40 + 8'(k), 0, 0, 0);
    check("R7 17th dropped", out_valid, 0);

    // R8 switch back with data queued
    send(8'h55, 0, 1);
    send(8'h66, 0, 1);
    send(8'h77, 0, 1);
    fifo_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 flushed", out_valid, 0);
    check("R8 overrun cleared", overrun, 0);
    check("R9 single mode rts", rts, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule